// File: doc/BRIEF.md
# Execution Unit Reservation and Local Share Bus Arbiter

This block sits after the dispatch slots of a compute unit have been filled for the cycle. Each execution unit has one dispatch slot. Every slot arrives with a status (empty, go or skip) and a mask of the execution units its instruction needs. The block settles which slots really dispatch and builds the cycle's reservation vector. It also flags any inconsistency in a sticky error bit.

One conflict gets special treatment. An instruction that addresses both memory spaces needs the global memory path and the local share bus together. When that instruction is ready in the global memory slot, it takes the local share bus. The local memory slot is forced to skip. If the local memory slot held a ready instruction, that instruction loses the bus. The block raises a one-cycle stall pulse and hands the losing wavefront id to a re-insert port, so the instruction can return to its schedule queue.

All results are registered and appear one clock after the slot inputs are presented. Nothing carries over from one cycle to the next except the error bit.

Top module: `resv_dispatch_arb`

## Requirements
- R1: `resv_o` bit u is 1 exactly when some slot whose final status is go has bit u set in its mask. It is rebuilt every cycle, and slots that are empty (code 0) or skip (code 2) contribute nothing.
- R2: All outputs are registered. The results for inputs presented before a rising edge appear right after that edge.
- R3: When the global memory slot (slot 4) has status go (code 1) with `gm_flat_i` high, and the local memory slot (slot 5) has status go, the following happen. Slot 5's final status becomes skip. Its mask is left out of `resv_o`. `lds_stall_o` and `reins_vld_o` are 1, and `reins_wave_o` equals `lm_wave_i`.
- R4: In the R3 case with slot 5 empty, slot 5's final status becomes skip and `lds_stall_o` and `reins_vld_o` stay 0.
- R5: If slot 4 is not go, or `gm_flat_i` is low, slot 5 is left untouched. When no re-insert happens, `reins_wave_o` is 0.
- R6: If two go slots set the same mask bit in one cycle, `resv_err_o` becomes 1.
- R7: If a go slot's mask has more than one bit set while slot 5's final status is not skip, `resv_err_o` becomes 1.
- R8: If slot 5's final status is skip without slot 4 being go with `gm_flat_i` high, `resv_err_o` becomes 1. A skip that comes with such a flat instruction raises no error.
- R9: `resv_err_o` stays 1 until reset. Reset clears every output to 0.
- R10: Every slot other than slot 5 has its final status equal to its input status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_stat_i | input | NUM_SLOTS*2 | Per-slot status, slot i in bits [2i+1:2i]: 0 empty, 1 go, 2 skip |
| gm_flat_i | input | 1 | Instruction in the global memory slot uses both memory paths |
| slot_mask_i | input | NUM_SLOTS*NUM_UNITS | Per-slot unit mask, slot i in bits [NUM_UNITS*i +: NUM_UNITS] |
| lm_wave_i | input | WAVE_W | Wavefront id held in the local memory slot |
| resv_o | output | NUM_UNITS | Units reserved this cycle |
| disp_stat_o | output | NUM_SLOTS*2 | Final per-slot status, same encoding as input |
| lds_stall_o | output | 1 | Local share bus arbitration stall pulse |
| reins_vld_o | output | 1 | Losing local memory instruction to be re-inserted |
| reins_wave_o | output | WAVE_W | Wavefront id of the re-inserted instruction |
| resv_err_o | output | 1 | Sticky reservation error |

## Verification
The hardest case to reach is an arbitration loss mixed with other go slots. The flat instruction's mask overlaps the local memory slot's unit there. The design must drop the loser's mask before it accumulates, or it reports a false clash. The stimulus drives a flat go in slot 4 together with a ready slot 5 and an unrelated go slot. It expects the merged vector without slot 5's bit and with no error. Each error source is then hit in isolation, with a reset between them. This shows both that the sticky bit holds and that each source sets it alone.

// File: rtl/resv_pkg.sv
`timescale 1ns/1ps
package resv_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_GO    = 2'd1,
    SLOT_SKIP  = 2'd2,
    SLOT_RSVD  = 2'd3
  } slot_st_e;
endpackage

// File: rtl/lds_bus_arb.sv
`timescale 1ns/1ps
module lds_bus_arb
  import resv_pkg::*;
#(
  parameter int NUM_SLOTS = 6,
  parameter int GM_SLOT   = 4,
  parameter int LM_SLOT   = 5
) (
  input  logic [NUM_SLOTS*2-1:0] stat_i,
  input  logic                   gm_flat_i,
  output logic [NUM_SLOTS*2-1:0] stat_o,
  output logic                   flat_go_o,
  output logic                   lose_o
);
  logic lm_busy;

  always_comb begin
    flat_go_o = (stat_i[GM_SLOT*2 +: 2] == SLOT_GO) && gm_flat_i;
    lm_busy   = (stat_i[LM_SLOT*2 +: 2] == SLOT_GO);
    lose_o    = flat_go_o && lm_busy;
    stat_o    = stat_i;
    if (flat_go_o) begin
      stat_o[LM_SLOT*2 +: 2] = SLOT_SKIP;
    end
  end
endmodule

// File: rtl/resv_accum.sv
`timescale 1ns/1ps
module resv_accum #(
  parameter int NUM_SLOTS = 6,
  parameter int NUM_UNITS = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SLOTS-1:0]           go_i,
  input  logic [NUM_SLOTS*NUM_UNITS-1:0] mask_i,
  output logic [NUM_UNITS-1:0]           resv_o,
  output logic                           clash_o,
  output logic                           wide_o
);
  localparam logic [NUM_UNITS-1:0] ONE = NUM_UNITS'(1);

  logic [NUM_UNITS-1:0] acc   [NUM_SLOTS+1];
  logic                 clash [NUM_SLOTS+1];
  logic                 wide  [NUM_SLOTS+1];

  assign acc[0]   = '0;
  assign clash[0] = 1'b0;
  assign wide[0]  = 1'b0;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic [NUM_UNITS-1:0] m;
    assign m = go_i[i] ? mask_i[i*NUM_UNITS +: NUM_UNITS] : '0;
    assign acc[i+1]   = acc[i] | m;
    assign clash[i+1] = clash[i] | (|(acc[i] & m));
    assign wide[i+1]  = wide[i] | (|(m & (m - ONE)));

    AST_GO_COVERED: assert property (@(posedge clk) disable iff (!rst_n)
      go_i[i] |-> ((mask_i[i*NUM_UNITS +: NUM_UNITS] & ~resv_o) == '0)); // R1
  end

  assign resv_o  = acc[NUM_SLOTS];
  assign clash_o = clash[NUM_SLOTS];
  assign wide_o  = wide[NUM_SLOTS];

  AST_IDLE_NO_RESV: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i == '0) |-> (resv_o == '0 && !clash_o)); // R1
endmodule

// File: rtl/skip_check.sv
`timescale 1ns/1ps
module skip_check
  import resv_pkg::*;
#(
  parameter int NUM_SLOTS = 6,
  parameter int LM_SLOT   = 5
) (
  input  logic [NUM_SLOTS*2-1:0] stat_i,
  input  logic                   flat_go_i,
  input  logic                   wide_i,
  output logic                   skip_err_o,
  output logic                   wide_err_o
);
  logic lm_skip;

  always_comb begin
    lm_skip    = (stat_i[LM_SLOT*2 +: 2] == SLOT_SKIP);
    skip_err_o = lm_skip && !flat_go_i;
    wide_err_o = wide_i && !lm_skip;
  end
endmodule

// File: rtl/resv_dispatch_arb.sv
`timescale 1ns/1ps
module resv_dispatch_arb
  import resv_pkg::*;
#(
  parameter int NUM_SLOTS = 6,
  parameter int NUM_UNITS = 6,
  parameter int GM_SLOT   = 4,
  parameter int LM_SLOT   = 5,
  parameter int WAVE_W    = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SLOTS*2-1:0]         slot_stat_i,
  input  logic                           gm_flat_i,
  input  logic [NUM_SLOTS*NUM_UNITS-1:0] slot_mask_i,
  input  logic [WAVE_W-1:0]              lm_wave_i,
  output logic [NUM_UNITS-1:0]           resv_o,
  output logic [NUM_SLOTS*2-1:0]         disp_stat_o,
  output logic                           lds_stall_o,
  output logic                           reins_vld_o,
  output logic [WAVE_W-1:0]              reins_wave_o,
  output logic                           resv_err_o
);
  logic [NUM_SLOTS*2-1:0] stat_fin;
  logic                   flat_go;
  logic                   lose;
  logic [NUM_SLOTS-1:0]   go_vec;
  logic [NUM_UNITS-1:0]   resv_d;
  logic                   clash;
  logic                   wide;
  logic                   skip_err;
  logic                   wide_err;
  logic                   err_d;
  logic [WAVE_W-1:0]      rwave_d;

  logic [NUM_UNITS-1:0]   resv_q;
  logic [NUM_SLOTS*2-1:0] stat_q;
  logic                   stall_q;
  logic                   rvld_q;
  logic [WAVE_W-1:0]      rwave_q;
  logic                   err_q;

  lds_bus_arb #(
    .NUM_SLOTS(NUM_SLOTS), .GM_SLOT(GM_SLOT), .LM_SLOT(LM_SLOT)
  ) u_arb (
    .stat_i(slot_stat_i), .gm_flat_i(gm_flat_i),
    .stat_o(stat_fin), .flat_go_o(flat_go), .lose_o(lose)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_go
    assign go_vec[i] = (stat_fin[i*2 +: 2] == SLOT_GO);
  end

  resv_accum #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_UNITS(NUM_UNITS)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .go_i(go_vec), .mask_i(slot_mask_i),
    .resv_o(resv_d), .clash_o(clash), .wide_o(wide)
  );

  skip_check #(
    .NUM_SLOTS(NUM_SLOTS), .LM_SLOT(LM_SLOT)
  ) u_chk (
    .stat_i(stat_fin), .flat_go_i(flat_go), .wide_i(wide),
    .skip_err_o(skip_err), .wide_err_o(wide_err)
  );

  always_comb begin
    err_d   = err_q | clash | skip_err | wide_err;
    rwave_d = lose ? lm_wave_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_q  <= '0;
      stat_q  <= '0;
      stall_q <= 1'b0;
      rvld_q  <= 1'b0;
      rwave_q <= '0;
      err_q   <= 1'b0;
    end else begin
      resv_q  <= resv_d;
      stat_q  <= stat_fin;
      stall_q <= lose;
      rvld_q  <= lose;
      rwave_q <= rwave_d;
      err_q   <= err_d;
    end
  end

  assign resv_o       = resv_q;
  assign disp_stat_o  = stat_q;
  assign lds_stall_o  = stall_q;
  assign reins_vld_o  = rvld_q;
  assign reins_wave_o = rwave_q;
  assign resv_err_o   = err_q;

  AST_STALL_REINSERT: assert property (@(posedge clk) disable iff (!rst_n)
    lds_stall_o |-> (reins_vld_o && disp_stat_o[LM_SLOT*2 +: 2] == SLOT_SKIP)); // R3
  AST_NO_WAVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !reins_vld_o |-> (reins_wave_o == '0)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    resv_err_o |=> resv_err_o); // R9
  AST_LM_NOT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_stat_o[LM_SLOT*2 +: 2] == SLOT_SKIP && !resv_err_o) |->
      (disp_stat_o[GM_SLOT*2 +: 2] == SLOT_GO)); // R8

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_pass
    if (i != LM_SLOT) begin : g_chk
      AST_STAT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (disp_stat_o[i*2 +: 2] == $past(slot_stat_i[i*2 +: 2]))); // R10
    end
  end
endmodule

// File: tb/resv_dispatch_arb_tb.sv
`timescale 1ns/1ps
module resv_dispatch_arb_tb;
  localparam logic [1:0] E = 2'd0;
  localparam logic [1:0] G = 2'd1;
  localparam logic [1:0] K = 2'd2;
  localparam logic [5:0] Z = 6'b000000;

  typedef struct {
    logic [5:0]  resv;
    logic [11:0] stat;
    logic        stall;
    logic        rvld;
    logic [5:0]  rwave;
    logic        err;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] slot_stat_i = '0;
  logic        gm_flat_i = 1'b0;
  logic [35:0] slot_mask_i = '0;
  logic [5:0]  lm_wave_i = '0;
  logic [5:0]  resv_o;
  logic [11:0] disp_stat_o;
  logic        lds_stall_o;
  logic        reins_vld_o;
  logic [5:0]  reins_wave_o;
  logic        resv_err_o;

  int n_chk = 0;
  int n_fail = 0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  resv_dispatch_arb u_dut (
    .clk(clk), .rst_n(rst_n), .slot_stat_i(slot_stat_i), .gm_flat_i(gm_flat_i),
    .slot_mask_i(slot_mask_i), .lm_wave_i(lm_wave_i), .resv_o(resv_o),
    .disp_stat_o(disp_stat_o), .lds_stall_o(lds_stall_o), .reins_vld_o(reins_vld_o),
    .reins_wave_o(reins_wave_o), .resv_err_o(resv_err_o)
  );

  task automatic drive(input logic [11:0] st, input logic fl, input logic [35:0] mk,
                       input logic [5:0] wv, input logic [5:0] e_resv,
                       input logic [11:0] e_stat, input logic e_stall,
                       input logic [5:0] e_rwave, input logic e_err, input string tag);
    exp_t it;
    @(negedge clk);
    slot_stat_i = st; gm_flat_i = fl; slot_mask_i = mk; lm_wave_i = wv;
    it.resv = e_resv; it.stat = e_stat; it.stall = e_stall; it.rvld = e_stall;
    it.rwave = e_rwave; it.err = e_err; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic check_zero(input string tag);
    n_chk++;
    if (resv_o !== '0 || disp_stat_o !== '0 || lds_stall_o !== 1'b0 ||
        reins_vld_o !== 1'b0 || reins_wave_o !== '0 || resv_err_o !== 1'b0) begin
      n_fail++;
      $display("FAIL %s: resv=%b stat=%b stall=%b rvld=%b wave=%0d err=%b expected all zero",
               tag, resv_o, disp_stat_o, lds_stall_o, reins_vld_o, reins_wave_o, resv_err_o);
    end
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    slot_stat_i = '0; gm_flat_i = 1'b0; slot_mask_i = '0; lm_wave_i = '0;
    repeat (2) @(negedge clk);
    check_zero(tag);
    rst_n = 1'b1;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (resv_o !== e.resv || disp_stat_o !== e.stat || lds_stall_o !== e.stall ||
            reins_vld_o !== e.rvld || reins_wave_o !== e.rwave || resv_err_o !== e.err) begin
          n_fail++;
          $display("FAIL %s: got resv=%b stat=%b stall=%b rvld=%b wave=%0d err=%b exp resv=%b stat=%b stall=%b rvld=%b wave=%0d err=%b",
                   e.tag, resv_o, disp_stat_o, lds_stall_o, reins_vld_o, reins_wave_o, resv_err_o,
                   e.resv, e.stat, e.stall, e.rvld, e.rwave, e.err);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    repeat (2) @(negedge clk);
    check_zero("R9 reset state");
    rst_n = 1'b1;
    // R1 all empty
    drive({E,E,E,E,E,E}, 0, '0, 6'd0, Z, {E,E,E,E,E,E}, 0, 6'd0, 0, "R1 idle");
    // R1 R2 R10 four single-unit go slots
    drive({E,E,G,G,G,G}, 0, {Z,Z,6'b001000,6'b000100,6'b000010,6'b000001}, 6'd3,
          6'b001111, {E,E,G,G,G,G}, 0, 6'd0, 0, "R1 R10 four slots");
    // R5 non-flat in global slot leaves local slot alone
    drive({G,G,E,E,E,E}, 0, {6'b100000,6'b010000,Z,Z,Z,Z}, 6'd5,
          6'b110000, {G,G,E,E,E,E}, 0, 6'd0, 0, "R5 non-flat");
    // R3 flat beats ready local slot
    drive({G,G,E,E,E,E}, 1, {6'b100000,6'b110000,Z,Z,Z,Z}, 6'd7,
          6'b110000, {K,G,E,E,E,E}, 1, 6'd7, 0, "R3 flat wins");
    // R1 R3 stall is a pulse, reservations cleared
    drive({E,E,E,E,E,E}, 0, '0, 6'd7, Z, {E,E,E,E,E,E}, 0, 6'd0, 0, "R3 pulse ends");
    // R4 flat with empty local slot
    drive({E,G,E,E,E,E}, 1, {Z,6'b110000,Z,Z,Z,Z}, 6'd2,
          6'b110000, {K,G,E,E,E,E}, 0, 6'd0, 0, "R4 flat no loser");
    // R3 loss mixed with another go slot
    drive({G,G,E,E,E,G}, 1, {6'b100000,6'b110000,Z,Z,Z,6'b000001}, 6'd9,
          6'b110001, {K,G,E,E,E,G}, 1, 6'd9, 0, "R3 mixed");
    // R1 R10 skip slot reserves nothing
    drive({E,E,E,K,E,E}, 0, {Z,Z,Z,6'b000100,Z,Z}, 6'd0,
          Z, {E,E,E,K,E,E}, 0, 6'd0, 0, "R1 skip slot");
    // R1 empty slot mask ignored, no clash
    drive({E,E,E,E,E,G}, 0, {Z,Z,Z,Z,6'b000010,6'b000010}, 6'd0,
          6'b000010, {E,E,E,E,E,G}, 0, 6'd0, 0, "R1 empty mask ignored");
    // R6 double reservation
    drive({E,E,E,E,G,G}, 0, {Z,Z,Z,Z,6'b000010,6'b000010}, 6'd0,
          6'b000010, {E,E,E,E,G,G}, 0, 6'd0, 1, "R6 clash");
    // R9 error sticks
    drive({E,E,E,E,E,E}, 0, '0, 6'd0, Z, {E,E,E,E,E,E}, 0, 6'd0, 1, "R9 sticky");
    do_reset("R9 reset clears error");
    // R7 multi-unit without flat skip
    drive({E,E,E,E,G,E}, 0, {Z,Z,Z,Z,6'b000110,Z}, 6'd0,
          6'b000110, {E,E,E,E,G,E}, 0, 6'd0, 1, "R7 wide mask");
    do_reset("R9 reset after R7");
    // R8 local skip with no flat partner
    drive({K,E,E,E,E,E}, 0, {6'b100000,Z,Z,Z,Z,Z}, 6'd0,
          Z, {K,E,E,E,E,E}, 0, 6'd0, 1, "R8 orphan skip");
    do_reset("R9 reset after R8");
    // R8 skip with flat partner is legal
    drive({K,G,E,E,E,E}, 1, {Z,6'b110000,Z,Z,Z,Z}, 6'd4,
          6'b110000, {K,G,E,E,E,E}, 0, 6'd0, 0, "R8 legal skip");
    // R5 flat flag with global slot skipping
    drive({G,K,E,E,E,E}, 1, {6'b100000,Z,Z,Z,Z,Z}, 6'd6,
          6'b100000, {G,K,E,E,E,E}, 0, 6'd0, 0, "R5 flat not go");
    drive({E,E,E,E,E,E}, 0, '0, 6'd0, Z, {E,E,E,E,E,E}, 0, 6'd0, 0, "R9 no error");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule